// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial stream. A write strobe places a character in a one-entry holding register. As soon as the shifter is idle, the character moves into a shift register. It is then sent as a start bit, 5 to 8 data bits (least significant first), an optional parity bit and a programmable stop period.

All bit timing comes from a single-cycle oversampling tick supplied from outside. Each bit lasts 16 ticks. A line-control byte selects:

- the character length,
- the stop length,
- the parity mode (normal odd or even, or a fixed "stick" value),
- a break override that holds the line low without disturbing the shifting logic.

Two status outputs report whether the holding register can take a new character and whether the whole transmitter has drained. They are used to pace writes from a bus or from a buffer.

Top module: `async_serial_tx`

## Requirements
- R1: After a character leaves the holding register, the line sends a start bit at 0 for 16 ticks. The data bits follow, least significant first, each for 16 ticks. `lineCfg[1:0]` selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8.
- R2: `lineCfg[2]` selects the stop period, sent at 1. When it is 0 the stop period is 16 ticks. When it is 1 the stop period is 24 ticks for 5-bit characters and 32 ticks for 6-, 7- and 8-bit characters. The frame ends, and the transmitter counts as idle, on the last stop tick.
- R3: With `lineCfg[3]`=1 and `lineCfg[5]`=0, one parity bit of 16 ticks is sent between the last data bit and the stop period. When `lineCfg[4]`=0 it makes the count of ones across data and parity odd. When `lineCfg[4]`=1 it makes that count even.
- R4: With `lineCfg[3]`=1 and `lineCfg[5]`=1, the parity bit is the constant 0 when `lineCfg[4]`=1 and the constant 1 when `lineCfg[4]`=0.
- R5: While `lineCfg[6]`=1 the serial output is 0. The frame timing and the status flags behave exactly as without break. The line returns to its normal value as soon as break is cleared.
- R6: A write clears `holdEmpty` from the next clock. When the shifter is idle, the held character moves to the shifter one clock after the write, and `holdEmpty` sets in that same clock. A write made while a frame is in progress waits in the holding register until that frame ends.
- R7: `txEmpty` is 1 only when the holding register is empty and no frame is in progress. When a character is waiting, it stays 0 across the boundary between two back-to-back frames.
- R8: After reset `serOut`, `holdEmpty` and `txEmpty` are all 1, and the line is 1 whenever the transmitter is idle and break is off.
- R9: Data bits above the selected length are neither sent nor counted for parity.
- R10: The format fields `lineCfg[5:0]` are captured when a character enters the shifter. Changing them during a frame does not change that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Oversampling tick, one clock wide, 16 per bit |
| wrEn | input | 1 | Load `wrData` into the holding register |
| wrData | input | DATA_W | Character to send |
| lineCfg | input | 7 | [1:0] length, [2] long stop, [3] parity on, [4] even select, [5] stick, [6] break |
| serOut | output | 1 | Serial line, idles at 1 |
| holdEmpty | output | 1 | Holding register can accept a character |
| txEmpty | output | 1 | Holding register and shifter both empty |

## Verification
The bench measures each frame by counting consumed ticks from the load clock. This exposes a stop period of the wrong length: 24 versus 32 ticks when 5-bit characters use the long stop, or a half stop applied to every length. It also catches an off-by-one in the bit counter that adds or drops a data bit.

Parity is checked with data whose bits above the selected length would flip the parity, so masking before the parity fold is verified. Both stick values are exercised, which catches inverted stick parity.

A break frame must keep the same length and status timing, which catches a design that stalls the shifter during break. A back-to-back pair catches `txEmpty` pulsing between frames. A mid-frame format change catches a shifter that reads the live configuration instead of the captured one.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // Frame phases of the shifter
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } txPhaseT;

  // Character format, same bit order as lineCfg[5:0]
  typedef struct packed {
    logic       stick;
    logic       evenSel;
    logic       parEn;
    logic       stopSel;
    logic [1:0] wlen;
  } txFmtT;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic shift;
  } txStrobeT;

  localparam int MIN_WORD = 5;

endpackage

// File: rtl/serTxCtrl.sv
module serTxCtrl
  import sertx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     tickEn,
  input  logic     holdFull,
  input  txFmtT    fmtQ,
  output txPhaseT  phase,
  output txStrobeT strobe
);

  localparam int HALF  = OVS / 2;
  localparam int CNT_W = $clog2(2 * OVS);
  localparam int BIT_W = $clog2(DATA_W);

  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] lastTick;
  logic [BIT_W-1:0] bitCnt;
  logic [BIT_W-1:0] lastBit;
  logic             bitEnd;
  txPhaseT          phaseNext;

  // Index of the final data bit for the captured length
  always_comb lastBit = BIT_W'(MIN_WORD - 1) + BIT_W'(fmtQ.wlen);

  // Tick count of the current phase, minus one
  always_comb begin
    lastTick = CNT_W'(OVS - 1);
    if (phase == PH_STOP && fmtQ.stopSel) begin
      if (fmtQ.wlen == 2'd0) lastTick = CNT_W'(OVS + HALF - 1);
      else                   lastTick = CNT_W'(2 * OVS - 1);
    end
  end

  always_comb bitEnd = tickEn && (phase != PH_IDLE) && (tickCnt == lastTick);

  always_comb begin
    strobe.load  = (phase == PH_IDLE) && holdFull;
    strobe.shift = bitEnd && (phase == PH_DATA);
  end

  always_comb begin
    phaseNext = phase;
    case (phase)
      PH_IDLE:  if (holdFull) phaseNext = PH_START;
      PH_START: if (bitEnd) phaseNext = PH_DATA;
      PH_DATA:  if (bitEnd && bitCnt == lastBit)
                  phaseNext = fmtQ.parEn ? PH_PAR : PH_STOP;
      PH_PAR:   if (bitEnd) phaseNext = PH_STOP;
      PH_STOP:  if (bitEnd) phaseNext = PH_IDLE;
      default:  phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      phase <= phaseNext;
      if (phase == PH_IDLE) begin
        tickCnt <= '0;
        bitCnt  <= '0;
      end else if (tickEn) begin
        tickCnt <= bitEnd ? '0 : tickCnt + 1'b1;
        if (strobe.shift) bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // R1: without a tick an active frame holds its position
  assert_tick_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && !tickEn) |=> ($stable(phase) && $stable(tickCnt) && $stable(bitCnt)));

  // R1: a load always opens a start bit
  assert_load_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (phase == PH_START && tickCnt == '0));

  // R2: only the stop phase may count past one bit time
  assert_tick_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_STOP) |-> (tickCnt < CNT_W'(OVS)));

  // R1: data counter never exceeds the captured length
  assert_bit_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA) |-> (bitCnt <= lastBit));

endmodule

// File: rtl/serTxData.sv
module serTxData
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  txFmtT             cfgNow,
  input  logic              brk,
  input  txPhaseT           phase,
  input  txStrobeT          strobe,
  output logic              holdFull,
  output txFmtT             fmtQ,
  output logic              serOut
);

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] dataMask;
  logic [DATA_W-1:0] masked;
  logic              parBit;
  logic              parNext;
  logic              lineBit;

  // Keep only the bits within the selected length
  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      dataMask[i] = (i < MIN_WORD + int'(cfgNow.wlen));
    masked = holdReg & dataMask;
  end

  always_comb begin
    if (cfgNow.stick) parNext = ~cfgNow.evenSel;
    else              parNext = (^masked) ^ ~cfgNow.evenSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
      shReg    <= '0;
      parBit   <= 1'b0;
      fmtQ     <= '0;
    end else begin
      if (wrEn) begin
        holdReg  <= wrData;
        holdFull <= 1'b1;
      end else if (strobe.load) begin
        holdFull <= 1'b0;
      end
      if (strobe.load) begin
        shReg  <= masked;
        parBit <= parNext;
        fmtQ   <= cfgNow;
      end else if (strobe.shift) begin
        shReg <= shReg >> 1;
      end
    end
  end

  always_comb begin
    case (phase)
      PH_START: lineBit = 1'b0;
      PH_DATA:  lineBit = shReg[0];
      PH_PAR:   lineBit = parBit;
      default:  lineBit = 1'b1;
    endcase
    serOut = brk ? 1'b0 : lineBit;
  end

  // R6: a write always leaves the holding register occupied
  assert_write_fills_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> holdFull);

  // R6: a transfer without a new write frees the holding register
  assert_load_frees_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !wrEn) |=> !holdFull);

  // R10: captured format holds for the whole frame
  assert_fmt_locked_R10: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && !strobe.load) |=> $stable(fmtQ));

endmodule

// File: rtl/async_serial_tx.sv
module async_serial_tx
  import sertx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [6:0]        lineCfg,
  output logic              serOut,
  output logic              holdEmpty,
  output logic              txEmpty
);

  txPhaseT  phase;
  txStrobeT strobe;
  txFmtT    fmtQ;
  txFmtT    cfgNow;
  logic     holdFull;
  logic     brk;

  always_comb begin
    cfgNow = txFmtT'(lineCfg[5:0]);
    brk    = lineCfg[6];
  end

  serTxCtrl #(.OVS(OVS), .DATA_W(DATA_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .holdFull (holdFull),
    .fmtQ     (fmtQ),
    .phase    (phase),
    .strobe   (strobe)
  );

  serTxData #(.DATA_W(DATA_W)) data_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .cfgNow   (cfgNow),
    .brk      (brk),
    .phase    (phase),
    .strobe   (strobe),
    .holdFull (holdFull),
    .fmtQ     (fmtQ),
    .serOut   (serOut)
  );

  always_comb begin
    holdEmpty = !holdFull;
    txEmpty   = !holdFull && (phase == PH_IDLE);
  end

  // R5: break drives the line low
  assert_break_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    brk |-> !serOut);

  // R7: an empty transmitter implies an empty holding register
  assert_txempty_R7: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> holdEmpty);

  // R8: idle line marks high
  assert_idle_mark_R8: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && !brk) |-> serOut);

endmodule

// File: tb/async_serial_tx_tb_top.sv
module async_serial_tx_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [6:0] lineCfg = '0;
  logic       serOut;
  logic       holdEmpty;
  logic       txEmpty;

  int checks = 0;
  int errors = 0;
  int consumed = 0;
  logic [1:0] tdiv = '0;
  bit finished = 0;

  always #5 clk = ~clk;

  async_serial_tx dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrData(wrData),
    .lineCfg(lineCfg), .serOut(serOut), .holdEmpty(holdEmpty), .txEmpty(txEmpty)
  );

  // Tick every fourth clock
  always @(negedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tickEn <= (tdiv == 2'd3);
  end

  // Ticks consumed by the design
  always @(posedge clk) if (rstN && tickEn) consumed <= consumed + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitTo(input int target);
    while (consumed < target) @(negedge clk);
  endtask

  // Decode one frame whose load clock preceded the current negedge
  task automatic decodeFrame(input logic [5:0] fmt, input logic [7:0] data, input logic brkOn,
                             input int t0, input logic expectNext,
                             input string parTag, input string lenTag);
    int n = 5 + int'(fmt[1:0]);
    int par = int'(fmt[3]);
    int nbits = 1 + n + par;
    int stopT = fmt[2] ? ((n == 5) ? 24 : 32) : 16;
    logic [11:0] exp = '0;
    logic p = 1'b0;
    int len;
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      exp[1+i] = data[i];
      p ^= data[i];
    end
    if (par == 1) exp[n+1] = fmt[5] ? ~fmt[4] : (p ^ ~fmt[4]);
    for (int k = 0; k < nbits; k++) begin
      string req;
      waitTo(t0 + 8 + 16 * k);
      req = (k <= n) ? "R1" : parTag;
      if (brkOn) req = "R5";
      chk(serOut === (brkOn ? 1'b0 : exp[k]), req, int'(serOut), int'(brkOn ? 1'b0 : exp[k]));
      if (k == 0) chk(txEmpty == 1'b0, "R7", int'(txEmpty), 0);
    end
    waitTo(t0 + 8 + 16 * nbits);
    chk(serOut === ~brkOn, brkOn ? "R5" : "R2", int'(serOut), int'(~brkOn));
    while (!(expectNext ? holdEmpty : txEmpty)) begin
      if (txEmpty) bad++;
      @(negedge clk);
    end
    len = consumed - t0;
    chk(len == 16 * nbits + stopT, lenTag, len, 16 * nbits + stopT);
    if (expectNext) chk(bad == 0, "R7", bad, 0);
  endtask

  // Write a character while idle; returns at the negedge after its load
  task automatic writeIdle(input logic [6:0] cfg, input logic [7:0] d, output int t0);
    @(negedge clk);
    lineCfg = cfg;
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    chk(holdEmpty == 1'b0, "R6", int'(holdEmpty), 0);
    chk(txEmpty == 1'b0, "R7", int'(txEmpty), 0);
    @(negedge clk);
    chk(holdEmpty == 1'b1, "R6", int'(holdEmpty), 1);
    t0 = consumed;
  endtask

  task automatic sendChar(input logic [6:0] cfg, input logic [7:0] d,
                          input string parTag, input string lenTag);
    int t0;
    writeIdle(cfg, d, t0);
    decodeFrame(cfg[5:0], d, cfg[6], t0, 1'b0, parTag, lenTag);
    if (!cfg[6]) chk(serOut == 1'b1, "R8", int'(serOut), 1);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(serOut == 1'b1, "R8", int'(serOut), 1);
    chk(holdEmpty == 1'b1, "R8", int'(holdEmpty), 1);
    chk(txEmpty == 1'b1, "R8", int'(txEmpty), 1);
  endtask

  // R1 R2: 8 data bits, no parity, one stop
  task automatic test8N1();
    sendChar(7'b000_0011, 8'hA5, "R3", "R2");
  endtask

  // R2 R9: 5 bits, long stop (24 ticks), even parity, upper bits set
  task automatic test5E15();
    sendChar(7'b001_1100, 8'hF3, "R9", "R2");
  endtask

  // R2 R3: 7 bits, even parity, two stops
  task automatic test7E2();
    sendChar(7'b001_1110, 8'h3B, "R3", "R2");
  endtask

  // R3: 6 bits, odd parity, one stop
  task automatic test6O1();
    sendChar(7'b000_1001, 8'h2C, "R3", "R2");
  endtask

  // R4: both stick values
  task automatic testStick();
    sendChar(7'b011_1011, 8'h01, "R4", "R2");
    sendChar(7'b010_1011, 8'h01, "R4", "R2");
  endtask

  // R5: break holds line low with unchanged timing
  task automatic testBreak();
    sendChar(7'b100_1011, 8'h5A, "R5", "R5");
    lineCfg[6] = 1'b0;
    @(negedge clk);
    chk(serOut == 1'b1, "R5", int'(serOut), 1);
  endtask

  // R6 R7: second character written during a frame
  task automatic testBackToBack();
    int t0a;
    int t0b;
    writeIdle(7'b000_0011, 8'h96, t0a);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = 8'h3C;
    @(negedge clk);
    wrEn = 1'b0;
    chk(holdEmpty == 1'b0, "R6", int'(holdEmpty), 0);
    decodeFrame(6'b00_0011, 8'h96, 1'b0, t0a, 1'b1, "R3", "R6");
    t0b = consumed;
    decodeFrame(6'b00_0011, 8'h3C, 1'b0, t0b, 1'b0, "R3", "R7");
  endtask

  // R10: format change mid-frame applies to the next character only
  task automatic testCfgChange();
    int t0;
    writeIdle(7'b000_0011, 8'hC3, t0);
    lineCfg = 7'b001_1100;
    decodeFrame(6'b00_0011, 8'hC3, 1'b0, t0, 1'b0, "R10", "R10");
    lineCfg = 7'b000_0011;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    testReset();
    test8N1();
    test5E15();
    test7E2();
    test6O1();
    testStick();
    testBreak();
    testBackToBack();
    testCfgChange();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule